// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block runs single accesses from a processor core onto an external memory or I/O bus. The core offers a request with an address, write data, a direction bit and a space bit. The controller accepts the request, drives the bus, and holds the access open for a programmed number of software wait states. When the programmed count is two or more, the controller also watches an external ready input in the last programmed cycle and stretches the access by one cycle for every low sample. When the access ends, the controller returns a one-cycle done pulse and, for reads, the captured data.

The request side is a valid/ready channel. `req_ready` is high only while the controller is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. While the request waits, the core must hold `req_valid` and the request fields steady. The response side has no back-pressure: `rsp_valid` is a one-cycle pulse that the core must take when it appears, and `rsp_rdata` holds its value until the next read completes. Bus strobes and the read/write line are active low. An active-low output-disable input removes the drive enables of the bus-side control and data lines.

Top module: `xbus_wait_ctrl`

## Requirements
- R1: After reset the controller is idle. Both strobes (`bus_mstrb_n`, `bus_iostrb_n`) and `bus_rw_n` are high, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request is accepted only while idle. While an access is in progress, `req_ready` is 0 and a held request is not taken.
- R3: With `cfg_wait` = W sampled at acceptance and ready high, the strobe is low for exactly 1+W cycles. `rsp_valid` is high for exactly one cycle, the first cycle after the last strobe-low cycle.
- R4: When W is 2 or more, `bus_ready` is sampled in cycle index W of the access (counting from 0) and in every later cycle. Each low sample adds exactly one strobe-low cycle.
- R5: When W is 0 or 1, `bus_ready` is ignored and the access lasts exactly 1+W cycles.
- R6: `bus_rw_n` is 0 only during a write access (strobe low, `req_write`=1) and is 1 at all other times.
- R7: `req_io`=0 selects the memory space and drives `bus_mstrb_n` low. `req_io`=1 selects the I/O space and drives `bus_iostrb_n` low. The two strobes are never low together.
- R8: `bus_addr` and `bus_dout` equal the accepted request's values in every cycle of the access, including ready-extended cycles.
- R9: For a read, `rsp_rdata` takes the `bus_din` value that is present in the final strobe-low cycle.
- R10: Between two accesses, both strobes are high for at least one cycle. A request held waiting during an access starts after exactly one such cycle.
- R11: When `bus_off_n` is 0, `bus_ctl_oe` (which enables `bus_rw_n` and `bus_iostrb_n`) is 0 and `bus_dout_oe` is 0. When `bus_off_n` is 1, `bus_ctl_oe` is 1 and `bus_dout_oe` is 1 only during a write access.
- R12: Changing `cfg_wait` after acceptance has no effect on the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wait | input | WS_W (3) | Software wait-state count, sampled at acceptance |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | ADDR_W (16) | Request address |
| req_wdata | input | DATA_W (16) | Request write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| rsp_valid | output | 1 | One-cycle access-complete pulse |
| rsp_rdata | output | DATA_W (16) | Data captured on the last read |
| bus_addr | output | ADDR_W (16) | Bus address |
| bus_dout | output | DATA_W (16) | Bus write data |
| bus_dout_oe | output | 1 | Drive enable for bus write data |
| bus_din | input | DATA_W (16) | Bus read data |
| bus_rw_n | output | 1 | 1 = read/rest, 0 = write |
| bus_mstrb_n | output | 1 | Memory strobe, active low |
| bus_iostrb_n | output | 1 | I/O strobe, active low |
| bus_ctl_oe | output | 1 | Drive enable for read/write line and I/O strobe |
| bus_ready | input | 1 | External ready |
| bus_off_n | input | 1 | Output disable, active low |

## Verification
The done pulse of one access and the acceptance of the next request can fall in the same cycle. A core that keeps `req_valid` high while an access is in progress is accepted in the idle cycle that carries `rsp_valid`. The bench provokes this by issuing requests back to back, with waits of different lengths and with ready held low for some cycles. A scoreboard pairs each strobe run with the request that was queued for it. It judges the overlap by requiring exactly one strobe-high cycle between the runs, a run length of 1+W plus the counted low samples, and response data taken from the final cycle of the right access.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic {
    XB_IDLE = 1'b0,
    XB_BUSY = 1'b1
  } xb_state_e;

  // smallest wait-state count at which the ready input is honoured
  localparam int unsigned XB_READY_MIN_WS = 2;

  // number of address spaces that own a strobe (memory, I/O)
  localparam int unsigned XB_NSPACE = 2;
endpackage

// File: rtl/xbus_req_hold.sv
module xbus_req_hold #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              active,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic              in_write,
  input  logic              in_io,
  output logic [ADDR_W-1:0] h_addr,
  output logic [DATA_W-1:0] h_wdata,
  output logic              h_write,
  output logic              h_io
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_addr  <= '0;
      h_wdata <= '0;
      h_write <= 1'b0;
      h_io    <= 1'b0;
    end else if (load) begin
      h_addr  <= in_addr;
      h_wdata <= in_wdata;
      h_write <= in_write;
      h_io    <= in_io;
    end
  end

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> ($stable(h_addr) && $stable(h_wdata) && $stable(h_write) && $stable(h_io)));
endmodule

// File: rtl/xbus_wait_cnt.sv
module xbus_wait_cnt
  import xbus_pkg::*;
#(
  parameter int unsigned WS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [WS_W-1:0] ws_in,
  input  logic            active,
  input  logic            ready_in,
  output logic            finish
);
  localparam logic [WS_W-1:0] WS_ZERO = '0;
  localparam logic [WS_W-1:0] WS_ONE  = WS_W'(1);
  localparam logic [WS_W-1:0] WS_MIN  = WS_W'(XB_READY_MIN_WS);

  logic [WS_W-1:0] cnt;
  logic            samp_en;
  logic            at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= WS_ZERO;
      samp_en <= 1'b0;
    end else if (load) begin
      cnt     <= ws_in;
      samp_en <= (ws_in >= WS_MIN);
    end else if (active && (cnt != WS_ZERO)) begin
      cnt <= cnt - WS_ONE;
    end
  end

  assign at_last = active && (cnt == WS_ZERO);
  assign finish  = at_last && (!samp_en || ready_in);

  // R4
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_last && samp_en && !ready_in) |=> (active && cnt == WS_ZERO));

  // R12
  cnt_no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> (cnt <= $past(cnt)));

  // R5
  short_ws_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_last && !samp_en) |=> !active);
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              finish,
  input  logic              is_write,
  input  logic [DATA_W-1:0] bus_din,
  output logic              req_ready,
  output logic              load,
  output logic              busy,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  xb_state_e state, state_nx;

  assign req_ready = (state == XB_IDLE);
  assign load      = req_valid && req_ready;
  assign busy      = (state == XB_BUSY);

  always_comb begin
    state_nx = state;
    unique case (state)
      XB_IDLE: if (load)   state_nx = XB_BUSY;
      XB_BUSY: if (finish) state_nx = XB_IDLE;
      default: state_nx = XB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= XB_IDLE;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      state     <= state_nx;
      rsp_valid <= finish;
      if (finish && !is_write) rsp_rdata <= bus_din;
    end
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R3
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && finish) |=> (rsp_valid && !busy));

  // R2
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  // R10
  gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !busy);
endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
  import xbus_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic h_write,
  input  logic h_io,
  input  logic off_n,
  output logic mstrb_n,
  output logic iostrb_n,
  output logic rw_n,
  output logic ctl_oe,
  output logic dout_oe
);
  logic [XB_NSPACE-1:0] strb_n;

  generate
    for (genvar s = 0; s < XB_NSPACE; s++) begin : g_strb
      assign strb_n[s] = !(busy && (int'(h_io) == s));
    end
  endgenerate

  assign mstrb_n  = strb_n[0];
  assign iostrb_n = strb_n[1];
  assign rw_n     = !(busy && h_write);
  assign ctl_oe   = off_n;
  assign dout_oe  = off_n && busy && h_write;

  // R7
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~mstrb_n, ~iostrb_n}));

  // R6
  rw_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rw_n |-> (!mstrb_n || !iostrb_n));

  // R11
  off_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !off_n |-> (!ctl_oe && !dout_oe));
endmodule

// File: rtl/xbus_wait_ctrl.sv
module xbus_wait_ctrl
  import xbus_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned WS_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WS_W-1:0]   cfg_wait,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_write,
  input  logic              req_io,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_dout_oe,
  input  logic [DATA_W-1:0] bus_din,
  output logic              bus_rw_n,
  output logic              bus_mstrb_n,
  output logic              bus_iostrb_n,
  output logic              bus_ctl_oe,
  input  logic              bus_ready,
  input  logic              bus_off_n
);
  logic load, busy, finish, h_write, h_io;

  xbus_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .finish(finish),
    .is_write(h_write), .bus_din(bus_din), .req_ready(req_ready),
    .load(load), .busy(busy), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  xbus_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(load), .active(busy),
    .in_addr(req_addr), .in_wdata(req_wdata), .in_write(req_write), .in_io(req_io),
    .h_addr(bus_addr), .h_wdata(bus_dout), .h_write(h_write), .h_io(h_io)
  );

  xbus_wait_cnt #(.WS_W(WS_W)) u_wait (
    .clk(clk), .rst_n(rst_n), .load(load), .ws_in(cfg_wait),
    .active(busy), .ready_in(bus_ready), .finish(finish)
  );

  xbus_pins u_pins (
    .clk(clk), .rst_n(rst_n), .busy(busy), .h_write(h_write), .h_io(h_io),
    .off_n(bus_off_n), .mstrb_n(bus_mstrb_n), .iostrb_n(bus_iostrb_n),
    .rw_n(bus_rw_n), .ctl_oe(bus_ctl_oe), .dout_oe(bus_dout_oe)
  );
endmodule

// File: tb/xbus_wait_ctrl_tb.sv
module xbus_wait_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_wait = '0;
  logic        req_valid = 1'b0, req_ready;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic        req_write = 1'b0, req_io = 1'b0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata, bus_addr, bus_dout;
  logic        bus_dout_oe, bus_rw_n, bus_mstrb_n, bus_iostrb_n, bus_ctl_oe;
  logic [15:0] bus_din = '0;
  logic        bus_ready = 1'b1;
  logic        bus_off_n = 1'b1;

  always #4 clk = ~clk;

  xbus_wait_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wait(cfg_wait), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_write(req_write), .req_io(req_io), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .bus_addr(bus_addr), .bus_dout(bus_dout),
    .bus_dout_oe(bus_dout_oe), .bus_din(bus_din), .bus_rw_n(bus_rw_n),
    .bus_mstrb_n(bus_mstrb_n), .bus_iostrb_n(bus_iostrb_n),
    .bus_ctl_oe(bus_ctl_oe), .bus_ready(bus_ready), .bus_off_n(bus_off_n)
  );

  typedef struct {
    logic [15:0] addr;
    logic [15:0] data;
    bit          wr;
    bit          io;
    bit          b2b;
    int          ws;
    int          low;
    int          len;
  } item_t;

  item_t sb_q[$];
  item_t cur;
  int    n_chk = 0, n_err = 0;
  bit    in_acc = 0, ended = 0;
  int    k = 0, gap = 100;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // driver: called 1 time unit after a falling edge
  task automatic drive(input logic [15:0] a, input logic [15:0] d, input bit wr,
                       input bit io, input int ws, input int low);
    item_t it;
    bit waited = 0;
    it.addr = a; it.data = d; it.wr = wr; it.io = io; it.ws = ws; it.low = low;
    it.len = 1 + ws + ((ws >= 2) ? low : 0);
    req_addr = a; req_wdata = d; req_write = wr; req_io = io;
    cfg_wait = ws[2:0]; req_valid = 1'b1;
    while (!req_ready) begin
      waited = 1;
      @(negedge clk); #1;
    end
    it.b2b = waited;
    sb_q.push_back(it);
    @(negedge clk); #1;
    req_valid = 1'b0;
    cfg_wait = ~ws[2:0];  // R12: later change must not matter
    req_addr = ~a; req_wdata = ~d;
  endtask

  task automatic quiet();
    do begin @(negedge clk); #1; end while (sb_q.size() != 0 || in_acc);
    repeat (2) begin @(negedge clk); #1; end
  endtask

  // bus responder and monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (!bus_mstrb_n || !bus_iostrb_n) begin
        if (!in_acc) begin
          if (sb_q.size() == 0) begin
            check(0, "R2 unexpected access", 1, 0);
            cur = '{default: 0};
          end else cur = sb_q.pop_front();
          in_acc = 1; k = 0;
          check(gap >= 1, "R10 gap", gap, 1);
          if (cur.b2b) check(gap == 1, "R10 back-to-back gap", gap, 1);
        end
        check(bus_mstrb_n == cur.io && bus_iostrb_n == !cur.io, "R7 strobe select",
              {bus_mstrb_n, bus_iostrb_n}, {cur.io, !cur.io});
        check(bus_rw_n == !cur.wr, "R6 rw level", bus_rw_n, !cur.wr);
        check(bus_addr == cur.addr, "R8 address", bus_addr, cur.addr);
        if (cur.wr) check(bus_dout == cur.data, "R8 write data", bus_dout, cur.data);
        check(req_ready == 1'b0, "R2 not ready while busy", req_ready, 0);
        check(bus_dout_oe == (cur.wr && bus_off_n), "R11 data oe", bus_dout_oe, cur.wr && bus_off_n);
        check(bus_ctl_oe == bus_off_n, "R11 ctl oe", bus_ctl_oe, bus_off_n);
        bus_din   = cur.addr ^ 16'(k);
        bus_ready = !(k >= cur.ws && k < cur.ws + cur.low);
        k++;
      end else begin
        if (in_acc) begin
          in_acc = 0;
          check(k == cur.len, "R3/R4/R5/R12 access length", k, cur.len);
          check(rsp_valid == 1'b1, "R3 done pulse", rsp_valid, 1);
          if (!cur.wr)
            check(rsp_rdata == (cur.addr ^ 16'(cur.len - 1)), "R9 read data",
                  rsp_rdata, cur.addr ^ 16'(cur.len - 1));
          gap = 1;
        end else begin
          gap++;
          check(rsp_valid == 1'b0, "R3 single pulse", rsp_valid, 0);
        end
        check(bus_rw_n == 1'b1, "R6 rw rests high", bus_rw_n, 1);
        check(bus_dout_oe == 1'b0, "R11 data oe idle", bus_dout_oe, 0);
        bus_ready = 1'b1;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    check(bus_mstrb_n && bus_iostrb_n, "R1 strobes high", {bus_mstrb_n, bus_iostrb_n}, 2'b11);
    check(bus_rw_n == 1'b1, "R1 rw high", bus_rw_n, 1);
    check(req_ready == 1'b1, "R1 ready", req_ready, 1);
    check(rsp_valid == 1'b0, "R1 no done", rsp_valid, 0);

    drive(16'h1234, 16'h0, 0, 0, 0, 0); quiet();        // R3 minimum
    drive(16'h2001, 16'hBEEF, 1, 1, 1, 3); quiet();     // R5 ready ignored
    drive(16'h0040, 16'h0, 0, 0, 0, 2); quiet();        // R5 W=0
    drive(16'h3300, 16'h0, 0, 0, 2, 0); quiet();        // R4 W=2 ready high
    drive(16'h4411, 16'h0, 0, 1, 2, 3); quiet();        // R4 stretched
    drive(16'h5522, 16'hCAFE, 1, 0, 7, 2); quiet();     // R4 R8 long write
    // R10 back-to-back chain
    drive(16'h6000, 16'h1111, 1, 0, 0, 0);
    drive(16'h6001, 16'h0, 0, 1, 3, 1);
    drive(16'h6002, 16'h2222, 1, 1, 1, 0);
    drive(16'h6003, 16'h0, 0, 0, 5, 4);
    quiet();
    // R11 output disable during a write
    bus_off_n = 1'b0;
    drive(16'h7777, 16'h5A5A, 1, 1, 3, 1); quiet();
    check(bus_ctl_oe == 1'b0, "R11 ctl oe off", bus_ctl_oe, 0);
    bus_off_n = 1'b1;
    @(negedge clk); #1;
    check(bus_ctl_oe == 1'b1, "R11 ctl oe on", bus_ctl_oe, 1);
    finish_run();
  end
endmodule